// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every data beat of one synchronous DRAM read or write burst. A start strobe carries the first column, a three-bit length code and an order bit. The first beat leaves the block in the same cycle as the strobe. The following beats come one per clock until the burst is complete, until a stop strobe arrives, or until a new start replaces the burst. Each beat is marked valid, and the final beat of a fixed-length burst is also marked last.

For fixed lengths the address stays inside the block of columns aligned to the burst length. In sequential order the low bits count up and wrap within that block. In interleaved order the low bits of the start column are XORed with the beat index. Full-page length counts through the whole page and wraps, and it runs until a stop or a new start. Full-page length is legal only in sequential order. An illegal request is refused and flagged for one cycle.

The control is a three-state machine. ST_IDLE has no burst running. ST_FIXED runs a burst of 2, 4 or 8 beats. ST_PAGE runs a full-page burst. A legal start leads from any state to ST_FIXED or ST_PAGE, or to ST_IDLE for a single-beat burst. An illegal start leads to ST_IDLE. A stop without a start leads to ST_IDLE. ST_FIXED goes to ST_IDLE after its last beat and otherwise stays in ST_FIXED. ST_PAGE stays in ST_PAGE until a stop or a start.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after reset with no start strobe, valid_o, last_o and reject_o are 0.
- R2: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats on consecutive cycles. last_o is high only on the final beat, and valid_o falls on the cycle after it unless a new start arrives.
- R3: With interleave_i=0 at the start, beat n of a fixed burst of length L keeps the column bits above log2(L) from the start column. Its low log2(L) bits equal (start low bits + n) mod L.
- R4: With interleave_i=1 at the start, beat n of a fixed burst of length L keeps the upper bits and has low log2(L) bits equal to start low bits XOR n.
- R5: Length code 7 with interleave_i=0 selects full page. Beat n is (start column + n) mod 2^COL_W, beats continue until a stop or a new start, and last_o is never high.
- R6: A start with length code 7 and interleave_i=1, or with length code 4, 5 or 6, is refused. reject_o is 1 in that cycle, valid_o is 0, and any running burst ends.
- R7: stop_i without start_i drops valid_o in the same cycle and ends the burst.
- R8: A legal start during a running burst outputs the new start column in that same cycle and continues the new sequence from it.
- R9: When start_i and stop_i are high together, the start takes effect and the stop is ignored.
- R10: The first beat (start column, valid_o=1) appears in the cycle of the start strobe, with no added latency.
- R11: The order bit and length code are sampled only with start_i. Changing them during a burst does not change its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst at start_col_i |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | 0..3: 1/2/4/8 beats, 7: full page, 4..6: illegal |
| interleave_i | input | 1 | 0 sequential order, 1 interleaved order |
| stop_i | input | 1 | End the running burst in this cycle |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| reject_o | output | 1 | Start request refused |

## Verification
Several properties are checked on every cycle. last_o and reject_o must be consistent with valid_o. A last beat or an unaccompanied stop must be followed by silence unless a new start comes. Beats must follow one another without gaps. A fixed burst must not leave its aligned column block, and a full-page burst must never raise last_o. The bench's scenarios are needed for the exact address orders (sequential wrap, XOR pattern, page wrap at the top column), for the burst lengths, for the refusal of each illegal code, for restarts and start-with-stop, and for showing that mid-burst changes to the order bit and length code are ignored.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam logic [2:0] LEN_CODE_PAGE = 3'd7;
    localparam logic [2:0] LEN_CODE_MAXFIX = 3'd3;
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec #(
    parameter int COL_W = 10
) (
    input  logic [2:0]       code_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             legal_o
);
    import bcg_pkg::*;

    // The mask covers the wrapping low bits; it equals burst length minus one.
    always_comb begin
        mask_o  = '1;
        page_o  = 1'b0;
        legal_o = 1'b0;
        if (code_i <= LEN_CODE_MAXFIX) begin
            mask_o  = COL_W'((32'd1 << code_i) - 32'd1);
            legal_o = 1'b1;
        end else if (code_i == LEN_CODE_PAGE) begin
            page_o  = 1'b1;
            legal_o = !interleave_i;
        end
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_xor;

    always_comb begin
        low_seq = base_i + beat_i;
        low_xor = base_i ^ beat_i;
        col_o   = (base_i & ~mask_i) |
                  ((interleave_i ? low_xor : low_seq) & mask_i);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             reject_o
);
    import bcg_pkg::*;

    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             il_q, il_d;

    logic [COL_W-1:0] new_mask;
    logic             new_page;
    logic             new_legal;
    logic [COL_W-1:0] run_col;

    burst_len_dec #(.COL_W(COL_W)) u_dec (
        .code_i       (len_code_i),
        .interleave_i (interleave_i),
        .mask_o       (new_mask),
        .page_o       (new_page),
        .legal_o      (new_legal)
    );

    burst_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i       (base_q),
        .beat_i       (beat_q),
        .mask_i       (mask_q),
        .interleave_i (il_q),
        .col_o        (run_col)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            il_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            mask_q  <= mask_d;
            il_q    <= il_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        mask_d  = mask_q;
        il_d    = il_q;
        if (start_i) begin
            if (new_legal) begin
                base_d = start_col_i;
                beat_d = COL_W'(1);
                mask_d = new_mask;
                il_d   = interleave_i;
                if (new_page)
                    state_d = ST_PAGE;
                else if (new_mask == '0)
                    state_d = ST_IDLE;
                else
                    state_d = ST_FIXED;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_FIXED: begin
                    if (stop_i || beat_q == mask_q)
                        state_d = ST_IDLE;
                    else
                        beat_d = beat_q + COL_W'(1);
                end
                ST_PAGE: begin
                    if (stop_i)
                        state_d = ST_IDLE;
                    else
                        beat_d = beat_q + COL_W'(1);
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        col_o    = run_col;
        valid_o  = 1'b0;
        last_o   = 1'b0;
        reject_o = 1'b0;
        if (start_i) begin
            if (new_legal) begin
                col_o   = start_col_i;
                valid_o = 1'b1;
                last_o  = !new_page && (new_mask == '0);
            end else begin
                reject_o = 1'b1;
            end
        end else if (state_q != ST_IDLE && !stop_i) begin
            valid_o = 1'b1;
            last_o  = (state_q == ST_FIXED) && (beat_q == mask_q);
        end
    end

    a_r2_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r2_last_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (!valid_o || start_i));

    a_r6_reject_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> (!valid_o && !last_o));

    a_r7_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!valid_o || start_i));

    a_r5_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !start_i) |-> !last_o);

    a_r3_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i && state_q == ST_FIXED) |->
            (((col_o ^ base_q) & ~mask_q) == '0));

    a_r10_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (valid_o || stop_i || start_i));
endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
    localparam int COL_W = 10;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             interleave_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, reject_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    bit m_active = 1'b0;
    int m_base = 0;
    int m_n = 0;
    int m_len = 0;     // 0 means full page
    bit m_il = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .reject_o(reject_o)
    );

    function automatic int exp_col(int base, int n, int len, bit il);
        int low;
        if (len == 0) return (base + n) % PAGE;
        low = il ? ((base % len) ^ n) : (((base % len) + n) % len);
        return (base - (base % len)) + low;
    endfunction

    task automatic check(string tag, bit ev, int ec, bit el, bit er);
        n_checks++;
        if (valid_o !== ev || reject_o !== er || last_o !== (ev & el) ||
            (ev && int'(col_o) != ec)) begin
            n_fail++;
            $display("FAIL %s: col=%0d valid=%0b last=%0b reject=%0b expected col=%0d valid=%0b last=%0b reject=%0b",
                     tag, col_o, valid_o, last_o, reject_o, ec, ev, ev & el, er);
        end
    endtask

    task automatic step(bit st, int col, int code, bit il, bit sp, string tag_in);
        bit legal, ev, el, er;
        int ec;
        string tag;
        @(negedge clk);
        start_i = st; start_col_i = COL_W'(col); len_code_i = 3'(code);
        interleave_i = il; stop_i = sp;
        #1;
        legal = (code <= 3) || (code == 7 && !il);
        ev = 0; el = 0; er = 0; ec = 0;
        if (st) begin
            if (legal) begin
                ev = 1; ec = col; el = (code == 0);
                tag = "R10";
                m_active = (code != 0); m_base = col; m_n = 1;
                m_len = (code == 7) ? 0 : (1 << code); m_il = il;
            end else begin
                er = 1; tag = "R6"; m_active = 0;
            end
        end else if (m_active && !sp) begin
            ev = 1;
            ec = exp_col(m_base, m_n, m_len, m_il);
            el = (m_len != 0) && (m_n == m_len - 1);
            tag = m_il ? "R4" : (m_len == 0 ? "R5" : "R3");
            if (el) m_active = 0;
            else m_n = (m_n + 1) % PAGE;
        end else begin
            tag = sp ? "R7" : "R2";
            m_active = 0;
        end
        if (tag_in != "") tag = tag_in;
        check(tag, ev, ec, el, er);
    endtask

    task automatic idle(int cycles, string tag);
        for (int i = 0; i < cycles; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7531);
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R2: each fixed length
        step(1, 37, 0, 0, 0, "R2"); idle(1, "R2");
        step(1, 37, 1, 0, 0, "R2"); idle(2, "R2");
        // R3: sequential 4-beat from 166 -> 166,167,164,165
        step(1, 166, 2, 0, 0, ""); idle(4, "R3");
        // R4: interleaved 8-beat from 13 -> 13,12,15,14,9,8,11,10
        step(1, 13, 3, 1, 0, ""); idle(8, "R4");
        step(1, 6, 2, 1, 0, ""); idle(4, "R4");
        // R5: full page wraps at the top column, then R7 stop
        step(1, PAGE - 4, 7, 0, 0, "R5"); idle(8, "R5");
        step(0, 0, 0, 0, 1, "R7"); idle(2, "R7");
        // R6: illegal requests, including one aborting a running burst
        step(1, 20, 7, 1, 0, "R6");
        step(1, 20, 3, 0, 0, ""); step(0, 0, 0, 0, 0, "");
        step(1, 20, 5, 0, 0, "R6"); idle(1, "R6");
        step(1, 20, 4, 1, 0, "R6"); step(1, 20, 6, 0, 0, "R6");
        // R8: restart mid-burst
        step(1, 100, 3, 0, 0, ""); step(0, 0, 0, 0, 0, "");
        step(1, 555, 2, 1, 0, "R8"); idle(4, "R8");
        // R9: start together with stop
        step(1, 300, 3, 0, 0, ""); step(1, 77, 1, 0, 1, "R9");
        step(0, 0, 0, 0, 0, "R9"); idle(1, "R9");
        // R11: flip order and length code mid-burst
        step(1, 250, 3, 0, 0, "");
        for (int i = 0; i < 7; i++) step(0, 0, 7 - i, i % 2, 0, "R11");
        idle(1, "R11");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            bit st, sp, il;
            int code, col;
            st = ($urandom % 6) == 0;
            sp = ($urandom % 12) == 0;
            il = $urandom % 2;
            code = ($urandom % 8 < 6) ? ($urandom % 4) : ($urandom % 8);
            col = $urandom % PAGE;
            step(st, col, code, il, sp, "");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule